// File: doc/BRIEF.md
# Programmable High-Frequency Reference Clock Divider

This block derives a high-frequency receive reference clock from an auxiliary clock. A 12-bit ratio code N sets the output period to N+1 auxiliary cycles. Code 0 passes the auxiliary clock through unchanged. A select bit picks either this internal clock or an external clock pin, and a polarity bit can invert the result. Software controls the block through one 32-bit control word. A write updates all writable fields. The read port always shows the control fields and the live status.

Changes to the divider are never applied in the middle of a period. A new ratio code is held pending until the running count wraps. From that point the new ratio governs every period. A one-shot adjustment makes the next period one auxiliary cycle longer or one cycle shorter, which lets software nudge the output phase. Two busy flags follow these changes: divide-busy for a ratio change and adjust-busy for an adjustment. A summary flag is set while either of them is set. A downstream bit-clock stage can be told when it should pass the reference straight through.

Top module: `hfclk_divider`

## Requirements
- R1: With the source select set to internal and ratio code N at bits 11:0, the output repeats every N+1 auxiliary cycles. Code 0 makes the output equal to the auxiliary clock.
- R2: For N of at least 1, each period starts with a high phase of floor((N+1)/2) auxiliary cycles, and the remaining cycles of the period are low.
- R3: Source select is bit 15. A value of 0 routes the external clock input to the output and a value of 1 routes the internal divider. After reset the bit reads 1.
- R4: Polarity is bit 14. A value of 1 inverts the selected clock and a value of 0 leaves it unchanged. After reset the bit reads 0.
- R5: A newly written ratio code takes effect only at the end of the current period. Divide-busy (bit 19) is set from the write until the first full period at the new ratio has ended, which is at most two output periods. A write of the ratio code already in effect does not set divide-busy.
- R6: The adjustment field is bits 17:16. Code 01 lengthens the next period by one auxiliary cycle, code 10 shortens it by one, and codes 00 and 11 change nothing. Adjust-busy (bit 18) is set from the request until the adjusted period has ended.
- R7: A shortening request is dropped when the ratio in effect for the next period is code 0 or 1. A lengthening request is dropped at code 0. A dropped request leaves the period lengths unchanged.
- R8: The summary busy bit (bit 20) always equals the OR of bits 19 and 18.
- R9: Read data returns the last written ratio code at bits 11:0. Bits 17:16, 13:12 and 31:21 always read 0.
- R10: The pass-through output is high exactly when both the bit-clock-internal input and the bit-clock-divide-by-one input are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aux_clk | input | 1 | Auxiliary clock; also clocks all block state |
| rst_n | input | 1 | Active-low reset, synchronous to aux_clk |
| ext_clk | input | 1 | External high-frequency clock pin |
| wr_en | input | 1 | Writes wr_data into the control word this cycle |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control fields and status |
| bclk_int | input | 1 | Downstream bit clock is generated internally |
| bclk_div_one | input | 1 | Downstream bit-clock divider is set to divide-by-1 |
| hf_clk | output | 1 | Selected and polarity-adjusted reference clock |
| hf_to_bitclk | output | 1 | Reference should pass straight to the bit clock |

## Verification
The divider is run at even and odd ratios, at divide-by-1 and divide-by-2, and at the maximum code. The even and odd ratios show whether the high-phase length is rounded down. The small codes expose the pass-through and degenerate-period paths. The maximum code shows whether the count width holds the longest and the lengthened period.

Ratio writes are placed in the middle of a period, and sometimes overwritten before they load. These writes show the difference between applying a ratio immediately and applying it at the wrap. They also show when divide-busy should fall. Adjustment requests of every code, issued at small and normal ratios, separate the applied nudges from the ignored ones. The external source is toggled under both polarities, which separates the source multiplexer from the inversion stage.

// File: rtl/hfd_pkg.sv
package hfd_pkg;

  localparam int REG_W    = 32;
  localparam int BIT_BUSY = 20;
  localparam int BIT_DIVB = 19;
  localparam int BIT_ADJB = 18;
  localparam int BIT_ADJ  = 16;
  localparam int BIT_SRC  = 15;
  localparam int BIT_POL  = 14;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'b00,
    ADJ_LONG  = 2'b01,
    ADJ_SHORT = 2'b10,
    ADJ_BOTH  = 2'b11
  } adj_e;

  // length of the high phase for ratio code n
  function automatic int unsigned high_cycles(int unsigned code);
    return (code + 1) / 2;
  endfunction

  // whether a one-shot request may be applied at ratio code n
  function automatic logic adj_allowed(adj_e req, int unsigned code);
    case (req)
      ADJ_LONG:  return code != 0;
      ADJ_SHORT: return code >= 2;
      default:   return 1'b0;
    endcase
  endfunction

  // true when a write carries an actual adjustment request
  function automatic logic adj_is_request(adj_e req);
    return (req == ADJ_LONG) || (req == ADJ_SHORT);
  endfunction

endpackage

// File: rtl/hfd_ctrl_regs.sv
module hfd_ctrl_regs
  import hfd_pkg::*;
#(
  parameter int DW      = 12,
  parameter bit SRC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [DW-1:0]    ratio_req,
  input  logic             divb,
  input  logic             adjb,
  output logic             src_sel,
  output logic             pol,
  output logic [DW-1:0]    wr_ratio,
  output adj_e             wr_adj,
  output logic [REG_W-1:0] rd_data
);

  // status positions and reserved bits are not writable
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[REG_W-1:BIT_ADJ+2], wr_data[BIT_POL-1:DW]};

  assign wr_ratio = wr_data[DW-1:0];
  assign wr_adj   = adj_e'(wr_data[BIT_ADJ +: 2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel <= SRC_RST;
      pol     <= 1'b0;
    end else if (wr_en) begin
      src_sel <= wr_data[BIT_SRC];
      pol     <= wr_data[BIT_POL];
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[DW-1:0]   = ratio_req;
    rd_data[BIT_POL]  = pol;
    rd_data[BIT_SRC]  = src_sel;
    rd_data[BIT_ADJB] = adjb;
    rd_data[BIT_DIVB] = divb;
    rd_data[BIT_BUSY] = divb | adjb;
  end

endmodule

// File: rtl/hfd_div_core.sv
module hfd_div_core
  import hfd_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_ratio,
  input  adj_e          wr_adj,
  output logic [DW-1:0] ratio_req,
  output logic [DW-1:0] n_act,
  output logic [DW:0]   cnt,
  output logic [DW:0]   tc,
  output logic          div_q,
  output logic          divb,
  output logic          adjb,
  output logic          wrap_ev,
  output logic          load_ev
);

  localparam int CW = DW + 1;

  logic [DW-1:0] hlen;
  logic          pend;
  logic          newrun;
  adj_e          adj_pend;
  logic          adj_run;

  logic [DW-1:0] n_nx;
  logic [DW-1:0] hlen_nx;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] tc_nx;
  logic [CW-1:0] base;
  logic          adj_ok;
  logic          pend_nx;
  logic          newrun_nx;
  adj_e          adj_pend_nx;
  logic          adj_run_nx;

  always_comb begin
    wrap_ev = (cnt == tc);
    load_ev = wrap_ev && pend;
    n_nx    = load_ev ? ratio_req : n_act;
    base    = {1'b0, n_nx};
    adj_ok  = wrap_ev && adj_allowed(adj_pend, 32'(n_nx));

    if (!wrap_ev) begin
      tc_nx = tc;
    end else if (adj_ok && adj_pend == ADJ_LONG) begin
      tc_nx = base + CW'(1);
    end else if (adj_ok && adj_pend == ADJ_SHORT) begin
      tc_nx = base - CW'(1);
    end else begin
      tc_nx = base;
    end

    cnt_nx  = wrap_ev ? '0 : cnt + CW'(1);
    hlen_nx = wrap_ev ? DW'(high_cycles(32'(n_nx))) : hlen;

    if (wr_en)        pend_nx = (wr_ratio != n_nx);
    else if (wrap_ev) pend_nx = 1'b0;
    else              pend_nx = pend;

    newrun_nx = wrap_ev ? pend : newrun;

    if (wr_en && adj_is_request(wr_adj)) adj_pend_nx = wr_adj;
    else if (wrap_ev)                    adj_pend_nx = ADJ_NONE;
    else                                 adj_pend_nx = adj_pend;

    adj_run_nx = wrap_ev ? adj_ok : adj_run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_req <= '0;
      n_act     <= '0;
      cnt       <= '0;
      tc        <= '0;
      hlen      <= '0;
      div_q     <= 1'b0;
      pend      <= 1'b0;
      newrun    <= 1'b0;
      adj_pend  <= ADJ_NONE;
      adj_run   <= 1'b0;
    end else begin
      if (wr_en) ratio_req <= wr_ratio;
      n_act    <= n_nx;
      cnt      <= cnt_nx;
      tc       <= tc_nx;
      hlen     <= hlen_nx;
      div_q    <= (cnt_nx < {1'b0, hlen_nx});
      pend     <= pend_nx;
      newrun   <= newrun_nx;
      adj_pend <= adj_pend_nx;
      adj_run  <= adj_run_nx;
    end
  end

  assign divb = pend | newrun;
  assign adjb = (adj_pend != ADJ_NONE) | adj_run;

endmodule

// File: rtl/hfd_clk_sel.sv
module hfd_clk_sel (
  input  logic aux_clk,
  input  logic ext_clk,
  input  logic div_q,
  input  logic bypass,
  input  logic src_sel,
  input  logic pol,
  input  logic bclk_int,
  input  logic bclk_div_one,
  output logic hf_clk,
  output logic hf_to_bitclk
);

  logic int_clk;
  logic pick_clk;

  assign int_clk      = bypass ? aux_clk : div_q;
  assign pick_clk     = src_sel ? int_clk : ext_clk;
  assign hf_clk       = pick_clk ^ pol;
  assign hf_to_bitclk = bclk_int & bclk_div_one;

endmodule

// File: rtl/hfclk_divider.sv
module hfclk_divider
  import hfd_pkg::*;
#(
  parameter int DW      = 12,
  parameter bit SRC_RST = 1'b1
) (
  input  logic             aux_clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             bclk_int,
  input  logic             bclk_div_one,
  output logic             hf_clk,
  output logic             hf_to_bitclk
);

  logic          src_sel;
  logic          pol;
  logic [DW-1:0] wr_ratio;
  adj_e          wr_adj;
  logic [DW-1:0] ratio_req;
  logic [DW-1:0] n_act;
  logic [DW:0]   cnt;
  logic [DW:0]   tc;
  logic          div_q;
  logic          divb;
  logic          adjb;
  logic          wrap_ev;
  logic          load_ev;
  logic          bypass;

  assign bypass = (n_act == '0);

  hfd_ctrl_regs #(.DW(DW), .SRC_RST(SRC_RST)) u_regs (
    .clk       (aux_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ratio_req (ratio_req),
    .divb      (divb),
    .adjb      (adjb),
    .src_sel   (src_sel),
    .pol       (pol),
    .wr_ratio  (wr_ratio),
    .wr_adj    (wr_adj),
    .rd_data   (rd_data)
  );

  hfd_div_core #(.DW(DW)) u_core (
    .clk       (aux_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ratio  (wr_ratio),
    .wr_adj    (wr_adj),
    .ratio_req (ratio_req),
    .n_act     (n_act),
    .cnt       (cnt),
    .tc        (tc),
    .div_q     (div_q),
    .divb      (divb),
    .adjb      (adjb),
    .wrap_ev   (wrap_ev),
    .load_ev   (load_ev)
  );

  hfd_clk_sel u_sel (
    .aux_clk      (aux_clk),
    .ext_clk      (ext_clk),
    .div_q        (div_q),
    .bypass       (bypass),
    .src_sel      (src_sel),
    .pol          (pol),
    .bclk_int     (bclk_int),
    .bclk_div_one (bclk_div_one),
    .hf_clk       (hf_clk),
    .hf_to_bitclk (hf_to_bitclk)
  );

endmodule

// File: rtl/hfclk_divider_chk.sv
module hfclk_divider_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrap_ev,
  input logic          load_ev,
  input logic [DW-1:0] n_act,
  input logic [DW:0]   cnt,
  input logic [DW:0]   tc,
  input logic          div_q,
  input logic          src_sel,
  input logic          pol,
  input logic          ext_clk,
  input logic          hf_clk,
  input logic [31:0]   rd_data
);

  assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= tc);

  assert_high_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> (cnt == '0));

  assert_ext_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel |-> (hf_clk == (ext_clk ^ pol)));

  assert_ratio_moves_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_act) |-> $past(wrap_ev));

  assert_divbusy_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> rd_data[19]);

  // R7 bounds are part of the same relation
  assert_period_nudge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> ((tc == {1'b0, n_act}) ||
                 ((tc == {1'b0, n_act} + 1'b1) && (n_act != '0)) ||
                 ((tc + 1'b1 == {1'b0, n_act}) && (n_act >= DW'(2)))));

  assert_busy_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[20] == (rd_data[19] | rd_data[18]));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:21] == '0) && (rd_data[17:16] == '0) && (rd_data[13:12] == '0));

endmodule

bind hfclk_divider hfclk_divider_chk #(.DW(DW)) u_chk (
  .clk     (aux_clk),
  .rst_n   (rst_n),
  .wrap_ev (wrap_ev),
  .load_ev (load_ev),
  .n_act   (n_act),
  .cnt     (cnt),
  .tc      (tc),
  .div_q   (div_q),
  .src_sel (src_sel),
  .pol     (pol),
  .ext_clk (ext_clk),
  .hf_clk  (hf_clk),
  .rd_data (rd_data)
);

// File: tb/hfclk_divider_bench.sv
module hfclk_divider_bench;

  logic        aux_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bclk_int = 1'b0;
  logic        bclk_div_one = 1'b0;
  logic        hf_clk;
  logic        hf_to_bitclk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  bit  ext_tog  = 1'b0;

  // reference model state
  int m_req, m_nact, m_pos, m_plen, m_hl, m_adjq;
  bit m_pend, m_newrun, m_adjrun, m_src, m_pol;

  always #5 aux_clk = ~aux_clk;

  hfclk_divider u_hfclk_divider (
    .aux_clk      (aux_clk),
    .rst_n        (rst_n),
    .ext_clk      (ext_clk),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .bclk_int     (bclk_int),
    .bclk_div_one (bclk_div_one),
    .hf_clk       (hf_clk),
    .hf_to_bitclk (hf_to_bitclk)
  );

  function automatic logic [31:0] word(bit src, bit pol, int adj, int ratio);
    logic [31:0] w;
    w = '0;
    w[15] = src;
    w[14] = pol;
    w[17:16] = 2'(adj);
    w[11:0] = 12'(ratio);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_req = 0; m_nact = 0; m_pos = 0; m_plen = 1; m_hl = 0; m_adjq = 0;
    m_pend = 0; m_newrun = 0; m_adjrun = 0; m_src = 1; m_pol = 0;
  endtask

  task automatic model_step(input bit we, input logic [31:0] wd);
    int n;
    if (m_pos == m_plen - 1) begin
      n = m_pend ? m_req : m_nact;
      m_newrun = m_pend;
      m_pend = 0;
      m_plen = n + 1;
      m_adjrun = 0;
      if (m_adjq == 1 && n != 0) begin m_plen++; m_adjrun = 1; end
      else if (m_adjq == 2 && n >= 2) begin m_plen--; m_adjrun = 1; end
      m_adjq = 0;
      m_nact = n;
      m_hl = (n + 1) / 2;
      m_pos = 0;
    end else begin
      m_pos++;
    end
    if (we) begin
      m_src = wd[15];
      m_pol = wd[14];
      m_req = int'(wd[11:0]);
      m_pend = (m_req != m_nact);
      if (wd[17:16] == 2'b01 || wd[17:16] == 2'b10) m_adjq = int'(wd[17:16]);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [31:0] e;
    bit db, ab;
    db = m_pend | m_newrun;
    ab = (m_adjq != 0) | m_adjrun;
    e = '0;
    e[11:0] = 12'(m_req);
    e[14] = m_pol;
    e[15] = m_src;
    e[18] = ab;
    e[19] = db;
    e[20] = db | ab;
    return e;
  endfunction

  function automatic logic exp_hf();
    logic b;
    if (!m_src)            b = ext_clk;
    else if (m_nact == 0)  b = 1'b0;   // aux clock is low at the sampling point
    else                   b = (m_pos < m_hl);
    return b ^ m_pol;
  endfunction

  // compare at the falling edge, then drive and advance the model
  task automatic tick(input bit we, input logic [31:0] wd);
    @(negedge aux_clk);
    chk("R1 R2 R3 R4 output clock", {31'b0, hf_clk}, {31'b0, exp_hf()});
    chk("R5 R6 R8 R9 read word", rd_data, exp_rd());
    chk("R10 pass-through", {31'b0, hf_to_bitclk}, {31'b0, bclk_int & bclk_div_one});
    wr_en = we;
    wr_data = wd;
    if (ext_tog) ext_clk = ~ext_clk;
    model_step(we, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0);
  endtask

  // independent period measurement from output rising edges
  task automatic measure(input int ncyc, input int exp_p, input string tag);
    int last;
    logic prev;
    last = -1;
    prev = hf_clk;
    for (int i = 0; i < ncyc; i++) begin
      tick(1'b0, '0);
      if (hf_clk && !prev) begin
        if (last >= 0) chk(tag, 32'(i - last), 32'(exp_p));
        last = i;
      end
      prev = hf_clk;
    end
  endtask

  task automatic wait_divb(input int limit, input string tag);
    int k;
    k = 0;
    while (rd_data[19] && k < limit + 5) begin
      tick(1'b0, '0);
      k++;
    end
    n_checks++;
    if (k > limit) begin
      n_fails++;
      $display("FAIL %s: divide-busy lasted %0d expected at most %0d", tag, k, limit);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge aux_clk);
    rst_n = 1'b1;
    chk("R3 R4 reset value", rd_data, 32'h0000_8000);
    model_step(1'b0, '0);

    // divide-by-1 then even ratio
    idle(4);
    tick(1'b1, word(1, 0, 0, 3));
    wait_divb(9, "R5 busy clears 1->4");
    measure(40, 4, "R1 divide-by-4");

    // odd ratio written mid-period
    idle(1);
    tick(1'b1, word(1, 0, 0, 4));
    wait_divb(11, "R5 busy clears 4->5");
    measure(40, 5, "R2 divide-by-5");

    // overwrite before load, then rewrite the same value
    idle(2);
    tick(1'b1, word(1, 0, 0, 9));
    tick(1'b1, word(1, 0, 0, 6));
    wait_divb(13, "R5 busy overwrite");
    measure(30, 7, "R1 divide-by-7");
    tick(1'b1, word(1, 0, 0, 6));
    chk("R5 same ratio no busy", {31'b0, rd_data[19]}, 32'd0);
    idle(10);

    // adjustments
    tick(1'b1, word(1, 0, 1, 6));
    idle(30);
    tick(1'b1, word(1, 0, 2, 6));
    idle(30);
    tick(1'b1, word(1, 0, 3, 6));
    idle(20);
    tick(1'b1, word(1, 0, 0, 1));
    idle(8);
    tick(1'b1, word(1, 0, 2, 1));
    measure(12, 2, "R7 short ignored at divide-by-2");
    tick(1'b1, word(1, 0, 1, 1));
    idle(12);
    tick(1'b1, word(1, 0, 0, 0));
    idle(6);
    tick(1'b1, word(1, 0, 1, 0));
    idle(6);
    tick(1'b1, word(1, 0, 2, 0));
    idle(6);

    // polarity on internal clock, external source both polarities
    tick(1'b1, word(1, 1, 0, 2));
    idle(20);
    ext_tog = 1'b1;
    tick(1'b1, word(0, 0, 0, 2));
    idle(12);
    tick(1'b1, word(0, 1, 0, 2));
    idle(12);
    ext_tog = 1'b0;

    // pass-through indication
    bclk_int = 1'b1; idle(2);
    bclk_div_one = 1'b1; idle(2);
    bclk_int = 1'b0; idle(2);
    bclk_div_one = 1'b0;

    // largest code, with a lengthened period
    tick(1'b1, word(1, 0, 0, 12'hFFF));
    wait_divb(4100, "R5 busy clears to 4096");
    measure(8300, 4096, "R1 divide-by-4096");
    tick(1'b1, word(1, 0, 1, 12'hFFF));
    idle(8300);
    tick(1'b1, word(1, 0, 0, 5));
    wait_divb(4105, "R5 busy clears 4096->6");
    measure(30, 6, "R1 divide-by-6");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge aux_clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule